// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns an effective address into a physical address by walking an in-memory radix tree. The caller gives it the address, a process number, the kind of access (read, write or execute) and whether the access comes from user mode. The caller also supplies the base and size of the process table. The walker reads the process entry for that process number. The entry gives the translated size, the root directory base and the root index width. From there the walker reads one directory entry per level until it reaches a leaf or a fault.

Each directory entry names the base and the index width of the next level. The index shift and mask are therefore recomputed at every level from a remaining-size value that shrinks as the walk goes down. At the leaf the walker checks the requested access against the page permissions. If the access is allowed, it marks the entry as referenced, and also as changed for writes. It writes the entry back only when that update altered it. All memory traffic goes through one 64-bit request port with a valid/ready handshake and a separate response strobe; writes are acknowledged on that strobe too. One translation is in flight at a time. It ends in a one-cycle done pulse that carries either a good translation or a nonzero cause vector.

Top module: `radix_walker`

## Requirements
- R1: The process table holds 2^(tbl_size+12) bytes in 16-byte entries. If req_pid×16 is at least that size, the walk ends with cause bit 0 (no entry) and issues no memory request.
- R2: The process entry is read at tbl_base + req_pid×16. In that doubleword, bits 61:56 give the remaining size, bits 55:8 (with low byte zero) give the root directory base, and bits 4:0 give the root index width.
- R3: At any level, an index width below 5 or above the remaining size ends the walk with cause bit 1 (bad configuration) and issues no read for that level.
- R4: The directory index is (EA >> (remaining − width)) masked to width bits, and the entry is read at base + index×8. The remaining size then drops by the width. A request holds its address while it is stalled.
- R5: An entry with bit 63 (valid) clear ends the walk with cause bit 0. An entry that is valid with bit 62 (leaf) clear supplies its bits 55:8 as the next base and bits 4:0 as the next width. Causes are one-hot.
- R6: A walk that reads 8 directory entries without reaching a leaf ends with cause bit 1.
- R7: For a leaf, the physical address is (entry bits 55:12 << 12) with bits below the remaining size replaced by the EA bits there, and page_shift equals the remaining size.
- R8: Leaf bits 2, 1 and 0 grant read, write and execute, and perm uses the same positions. If leaf bit 3 (privileged) is set and req_user is high, nothing is granted. Requesting an access that is not granted gives cause bit 2.
- R9: An execute access (req_kind 2) to a leaf whose bits 5:4 are 11 (I/O attribute) gives cause bit 3, and this check comes before the permission check.
- R10: After a granted leaf, bit 8 (referenced) is set, and bit 7 (changed) is set only for writes (req_kind 1). For non-writes, perm has its write bit cleared.
- R11: The updated leaf is written back to its own address only when it differs from the value read.
- R12: done is a one-cycle pulse. xlate_ok is high with it exactly when cause is zero. req_ready is high only while the walker is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a translation |
| req_ready | output | 1 | Walker idle, request accepted |
| req_ea | input | 64 | Effective address |
| req_pid | input | PID_W | Process number |
| req_kind | input | 2 | 0 read, 1 write, 2 execute |
| req_user | input | 1 | Access comes from user mode |
| tbl_base | input | 64 | Process table base address |
| tbl_size | input | 5 | Process table size exponent minus 12 |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 64 | Request address |
| mem_req_wdata | output | 64 | Write data |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Walk finished, one cycle |
| xlate_ok | output | 1 | Translation valid |
| pa | output | 64 | Physical address |
| page_shift | output | 6 | Log2 of page size |
| perm | output | 3 | Granted read/write/execute |
| cause | output | 4 | Fault cause, one-hot |

## Verification
The hardest case to reach from the ports is the depth cap. A legal-looking tree almost never gets eight levels deep without running out of remaining size. The bench builds a process entry with the largest remaining size and width 5, and points it at a directory whose entry 0 is a non-leaf that points back to the same directory. An address of zero then keeps selecting that self-loop, and the bench counts exactly nine reads before the bad-configuration fault. The write-back rule needs a dirty and a clean pass over the same leaf. A read, a write and a repeated read run back to back, and the bench checks that exactly one write carries each new bit and that the last pass writes nothing.

// File: rtl/radix_walker.sv
module radix_walker #(
  parameter int PID_W      = 20,
  parameter int MAX_LEVELS = 8,
  parameter int MIN_NLS    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [63:0]      req_ea,
  input  logic [PID_W-1:0] req_pid,
  input  logic [1:0]       req_kind,
  input  logic             req_user,
  input  logic [63:0]      tbl_base,
  input  logic [4:0]       tbl_size,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [63:0]      mem_req_addr,
  output logic [63:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data,
  output logic             done,
  output logic             xlate_ok,
  output logic [63:0]      pa,
  output logic [5:0]       page_shift,
  output logic [2:0]       perm,
  output logic [3:0]       cause
);
  localparam int LVL_W = (MAX_LEVELS > 1) ? $clog2(MAX_LEVELS) : 1;
  localparam logic [3:0] C_NOENT = 4'b0001, C_BADCFG = 4'b0010,
                         C_PROT  = 4'b0100, C_GUARD  = 4'b1000;

  typedef enum logic [2:0] {S_IDLE, S_IDX, S_REQ, S_RSP, S_DONE} st_t;
  typedef enum logic [1:0] {PH_PT, PH_DIR, PH_WB} ph_t;

  st_t              st;
  ph_t              ph;
  logic [63:0]      ea, base, maddr, wdata;
  logic [1:0]       kind;
  logic             user;
  logic [5:0]       rem;
  logic [4:0]       nls;
  logic [LVL_W-1:0] lvl;

  logic [PID_W+3:0] pt_off;
  logic             pt_over;
  assign pt_off  = {req_pid, 4'b0000};
  assign pt_over = (pt_off >> ({1'b0, tbl_size} + 6'd12)) != '0;

  logic        bad_lvl;
  logic [63:0] idx;
  assign bad_lvl = (nls < 5'(MIN_NLS)) || ({1'b0, nls} > rem);
  assign idx     = (ea >> (rem - {1'b0, nls})) & ((64'd1 << nls) - 64'd1);

  logic [63:0] d, pmask, rpn, upd;
  logic [2:0]  need, grant;
  logic        guard, denied;
  assign d      = mem_rsp_data;
  assign pmask  = (64'd1 << rem) - 64'd1;
  assign rpn    = {8'b0, d[55:12], 12'b0};
  assign need   = (kind == 2'd1) ? 3'b010 : (kind == 2'd2) ? 3'b001 : 3'b100;
  assign grant  = (d[3] && user) ? 3'b000 : d[2:0];
  assign guard  = (d[5:4] == 2'b11) && (kind == 2'd2);
  assign denied = (need & ~grant) != 3'b000;
  assign upd    = d | 64'h100 | ((kind == 2'd1) ? 64'h80 : 64'h0);

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_REQ);
  assign mem_req_we    = (ph == PH_WB);
  assign mem_req_addr  = maddr;
  assign mem_req_wdata = wdata;
  assign done          = (st == S_DONE);
  assign xlate_ok      = done && (cause == 4'b0000);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= PH_PT;
      ea <= '0; base <= '0; maddr <= '0; wdata <= '0;
      kind <= '0; user <= 1'b0; rem <= '0; nls <= '0; lvl <= '0;
      pa <= '0; page_shift <= '0; perm <= '0; cause <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          ea <= req_ea; kind <= req_kind; user <= req_user;
          cause <= '0; perm <= '0; pa <= '0; page_shift <= '0;
          ph <= PH_PT;
          if (pt_over) begin
            cause <= C_NOENT; st <= S_DONE;
          end else begin
            maddr <= tbl_base + 64'(pt_off); st <= S_REQ;
          end
        end
        S_IDX: begin
          if (bad_lvl) begin
            cause <= C_BADCFG; st <= S_DONE;
          end else begin
            maddr <= base + (idx << 3);
            rem   <= rem - {1'b0, nls};
            ph    <= PH_DIR; st <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) st <= S_RSP;
        S_RSP: if (mem_rsp_valid) begin
          unique case (ph)
            PH_PT: begin
              rem <= d[61:56]; base <= {8'b0, d[55:8], 8'b0}; nls <= d[4:0];
              lvl <= '0; st <= S_IDX;
            end
            PH_DIR: begin
              if (!d[63]) begin
                cause <= C_NOENT; st <= S_DONE;
              end else if (d[62]) begin
                if (guard) begin
                  cause <= C_GUARD; st <= S_DONE;
                end else if (denied) begin
                  cause <= C_PROT; st <= S_DONE;
                end else begin
                  pa         <= (rpn & ~pmask) | (ea & pmask);
                  page_shift <= rem;
                  perm       <= (kind == 2'd1) ? grant : (grant & 3'b101);
                  if (upd != d) begin
                    wdata <= upd; ph <= PH_WB; st <= S_REQ;
                  end else st <= S_DONE;
                end
              end else if (lvl == LVL_W'(MAX_LEVELS - 1)) begin
                cause <= C_BADCFG; st <= S_DONE;
              end else begin
                base <= {8'b0, d[55:8], 8'b0}; nls <= d[4:0];
                lvl  <= lvl + 1'b1; st <= S_IDX;
              end
            end
            default: st <= S_DONE;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic        xlate_ok,
  input logic [2:0]  perm,
  input logic [3:0]  cause,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic        mem_req_we,
  input logic [63:0] mem_req_addr,
  input logic [63:0] mem_req_wdata
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid || done) |-> !req_ready); // R12
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R4
  AST_WB_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n) (mem_req_valid && mem_req_we) |-> mem_req_wdata[8]); // R10
  AST_OK_HAS_PERM: assert property (@(posedge clk) disable iff (!rst_n) (done && xlate_ok) |-> (perm != 3'b000)); // R8
  AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) done |-> $onehot0(cause)); // R5
endmodule

bind radix_walker radix_walker_chk chk (.*);

// File: tb/tb_radix_walker.sv
module tb_radix_walker;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic req_valid = 0, req_ready, req_user = 0;
  logic [63:0] req_ea = 0, tbl_base = 64'h10000;
  logic [19:0] req_pid = 0;
  logic [1:0]  req_kind = 0;
  logic [4:0]  tbl_size = 0;
  logic mem_req_valid, mem_req_ready = 1, mem_req_we, mem_rsp_valid = 0;
  logic [63:0] mem_req_addr, mem_req_wdata, mem_rsp_data = 0;
  logic done, xlate_ok;
  logic [63:0] pa;
  logic [5:0]  page_shift;
  logic [2:0]  perm;
  logic [3:0]  cause;

  radix_walker dut (.*);

  int total = 0, bad = 0, nreads = 0, nwrites = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] last_waddr, last_wdata, pdata;
  logic pend = 0, stall = 0;
  logic [63:0] r_pa; logic [5:0] r_sh; logic [2:0] r_perm; logic [3:0] r_cause; logic r_ok;

  localparam logic [63:0] V = 64'h8000_0000_0000_0000, L = 64'h4000_0000_0000_0000;
  localparam logic [63:0] FREF = 64'h100, FCHG = 64'h80, FPRIV = 64'h8, FR = 64'h4, FW = 64'h2, FX = 64'h1, FIO = 64'h30;

  function automatic logic [63:0] pte_proc(input int rs, input logic [63:0] b, input int w);
    return (64'(rs) << 56) | b | 64'(w);
  endfunction
  function automatic logic [63:0] pte_dir(input logic [63:0] b, input int w);
    return V | b | 64'(w);
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid = 0;
    if (pend) begin
      mem_rsp_valid = 1; mem_rsp_data = pdata; pend = 0;
    end else begin
      mem_req_ready = stall ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend = 1;
        if (mem_req_we) begin
          mem[mem_req_addr] = mem_req_wdata; nwrites++;
          last_waddr = mem_req_addr; last_wdata = mem_req_wdata; pdata = 0;
        end else begin
          nreads++;
          pdata = mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [63:0] ea, input logic [19:0] pid, input logic [1:0] kind, input logic user);
    int cnt = 0;
    nreads = 0; nwrites = 0;
    @(negedge clk);
    req_ea = ea; req_pid = pid; req_kind = kind; req_user = user; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && cnt < 300) begin @(negedge clk); cnt++; end
    if (!done) chk("R12 walk timeout", 0, 1);
    r_pa = pa; r_sh = page_shift; r_perm = perm; r_cause = cause; r_ok = xlate_ok;
    @(negedge clk);
    chk("R12 done single cycle", {63'b0, done}, 0);
  endtask

  task automatic t_reset;
    chk("R12 reset done", {63'b0, done}, 0);
    chk("R12 reset ready", {63'b0, req_ready}, 1);
    chk("R12 reset mem idle", {63'b0, mem_req_valid}, 0);
  endtask

  task automatic t_pid_range;
    tbl_size = 0;
    walk(64'h1234, 20'd256, 0, 0);
    chk("R1 pid past table cause", r_cause, 4'b0001);
    chk("R1 no memory read", nreads, 0);
    chk("R12 not ok on fault", r_ok, 0);
  endtask

  task automatic t_small_page;
    logic [63:0] ea = 64'h1234_5678, a1, a2, leaf;
    a1 = 64'h20000 + (((ea >> 21) & 64'h1FF) << 3);
    a2 = 64'h30000 + (((ea >> 12) & 64'h1FF) << 3);
    leaf = V | L | 64'hABCD_E000 | FR | FW;
    mem[64'h10000 + 3*16] = pte_proc(30, 64'h20000, 9);
    mem[a1] = pte_dir(64'h30000, 9);
    mem[a2] = leaf;
    walk(ea, 3, 0, 0);
    chk("R12 ok", r_ok, 1);
    chk("R7 pa 4K", r_pa, 64'hABCD_E678);
    chk("R7 shift 4K", r_sh, 12);
    chk("R10 read drops write perm", r_perm, 3'b100);
    chk("R2 R4 three reads", nreads, 3);
    chk("R11 one write", nwrites, 1);
    chk("R11 write addr", last_waddr, a2);
    chk("R10 ref set no change", last_wdata, leaf | FREF);
    stall = 1;
    walk(ea, 3, 1, 0);
    stall = 0;
    chk("R10 write perm", r_perm, 3'b110);
    chk("R10 change bit written", last_wdata, leaf | FREF | FCHG);
    chk("R11 write under stall", nwrites, 1);
    walk(ea, 3, 0, 0);
    chk("R11 no write when unchanged", nwrites, 0);
    chk("R7 pa again", r_pa, 64'hABCD_E678);
  endtask

  task automatic t_large_page;
    logic [63:0] ea = 64'h0A5A_5A5A;
    mem[64'h10000 + 4*16] = pte_proc(30, 64'h20000, 9);
    mem[64'h20000 + (((ea >> 21) & 64'h1FF) << 3)] = V | L | 64'h4060_3000 | FR | FX | FREF;
    walk(ea, 4, 0, 0);
    chk("R7 pa 2M", r_pa, 64'h4060_0000 | (ea & 64'h1F_FFFF));
    chk("R7 shift 2M", r_sh, 21);
    chk("R8 perm read exec", r_perm, 3'b101);
    chk("R11 no write ref already set", nwrites, 0);
  endtask

  task automatic t_invalid;
    mem[64'h10000 + 5*16] = pte_proc(30, 64'h20000, 9);
    walk(64'h0200_0000, 5, 0, 0);
    chk("R5 invalid entry cause", r_cause, 4'b0001);
    chk("R5 reads", nreads, 2);
  endtask

  task automatic t_badcfg;
    mem[64'h10000 + 6*16] = pte_proc(30, 64'h20000, 4);
    walk(64'h0, 6, 0, 0);
    chk("R3 narrow index cause", r_cause, 4'b0010);
    chk("R3 no level read", nreads, 1);
    mem[64'h10000 + 9*16] = pte_proc(6, 64'h20000, 9);
    walk(64'h0, 9, 0, 0);
    chk("R3 width above remaining", r_cause, 4'b0010);
  endtask

  task automatic t_depth;
    mem[64'h10000 + 7*16] = pte_proc(63, 64'h50000, 5);
    mem[64'h50000] = pte_dir(64'h50000, 5);
    walk(64'h0, 7, 0, 0);
    chk("R6 depth cap cause", r_cause, 4'b0010);
    chk("R6 nine reads", nreads, 9);
  endtask

  task automatic t_perm;
    mem[64'h10000 + 8*16] = pte_proc(21, 64'h60000, 9);
    mem[64'h60000 + 5*8] = V | L | 64'h7000 | FR | FW | FPRIV;
    mem[64'h60000 + 6*8] = V | L | 64'h8000 | FR;
    mem[64'h60000 + 8*8] = V | L | 64'h9000 | FR | FX | FIO;
    walk(64'h5010, 8, 0, 1);
    chk("R8 user on privileged page", r_cause, 4'b0100);
    chk("R11 no write on fault", nwrites, 0);
    walk(64'h5010, 8, 0, 0);
    chk("R8 supervisor ok", r_pa, 64'h7010);
    walk(64'h6000, 8, 1, 0);
    chk("R8 write to read-only", r_cause, 4'b0100);
    walk(64'h8000, 8, 2, 0);
    chk("R9 exec on io", r_cause, 4'b1000);
    walk(64'h8004, 8, 0, 0);
    chk("R9 read on io ok", r_pa, 64'h9004);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL R12 watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_pid_range;
    t_small_page;
    t_large_page;
    t_invalid;
    t_badcfg;
    t_depth;
    t_perm;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule